// File: doc/BRIEF.md
# Iterative Unified-Mode CORDIC Engine

This block evaluates trigonometric, hyperbolic and multiply/divide style functions with a single shift-add datapath. That datapath is reused once per clock cycle until the computation is finished. A caller presents signed fixed-point x, y and z words, a steering-mode select and a coordinate-system select, and pulses a start strobe. The engine then loads the three words into its working registers. On every following cycle it applies one micro-rotation, until its step sequence ends. At that point it raises a one-cycle done pulse and holds the final x, y and z words on its outputs.

Each micro-rotation shifts the opposite branch by the current step index and then adds or subtracts it. The z branch adds or subtracts a constant taken from a table that the step index addresses. The steering decision comes from the sign of z (rotation) or of y (vectoring). The coordinate system selects circular, linear or hyperbolic constants and the sign of the x update. Gain correction is left to the caller: in circular mode the results carry K ≈ 1.6468, and in hyperbolic mode they carry about 0.8282.

All data words are two's complement with FRAC fraction bits (defaults: 18-bit words, 14 fraction bits, 16 steps). Angles are in radians with the same scaling.

Top module: `cordic_engine`

## Requirements
- R1: While reset is high and after it is released, busy_o and done_o are 0 and x_o, y_o and z_o read 0.
- R2: A start_i high while busy_o is low is accepted at that clock edge. The x_i, y_i, z_i, mode_i (0 = rotation, 1 = vectoring) and sys_i (0 = circular, 1 = linear, 2 = hyperbolic) values are captured, and busy_o is high in the following cycle.
- R3: A start_i high while busy_o is high has no effect: the running computation keeps its inputs, its results and its done timing.
- R4: done_o is high for exactly one cycle. It falls together with busy_o, N cycles after the accepting edge for circular and linear (16 by default), and one extra cycle for each repeated hyperbolic step (17 by default).
- R5: While idle and without an accepted start, x_o, y_o and z_o stay unchanged whatever the data inputs do.
- R6: Circular rotation (mode_i=0, sys_i=0) returns x = K(x·cos z − y·sin z), y = K(y·cos z + x·sin z) and z ≈ 0, for |z| up to about 1.7.
- R7: Circular vectoring (mode_i=1, sys_i=0) with x ≥ 0 returns x = K·sqrt(x²+y²), y ≈ 0 and z = z0 + atan(y/x).
- R8: Linear rotation (mode_i=0, sys_i=1) leaves x unchanged and returns y = y0 + x0·z0 and z ≈ 0, for |z0| below 2.
- R9: Linear vectoring (mode_i=1, sys_i=1) leaves x unchanged and returns z = z0 + y0/x0 and y ≈ 0, for |y0/x0| below 2.
- R10: Hyperbolic rotation (mode_i=0, sys_i=2) runs steps 1 to N−1, with steps 4 and 13 performed twice. It returns x = Kh(x·cosh z + y·sinh z) and y = Kh(y·cosh z + x·sinh z).
- R11: Hyperbolic vectoring (mode_i=1, sys_i=2) returns x = Kh·sqrt(x²−y²) and z = z0 + atanh(y/x), for |y/x| below 0.8.
- R12: The unused system code sys_i=3 behaves exactly as circular, both in its results and in its step count.
- R13: A start_i raised in the same cycle as done_o is accepted, so a new computation can begin with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| mode_i | input | 1 | Steering: 0 = rotation (z to zero), 1 = vectoring (y to zero) |
| sys_i | input | 2 | Coordinate system: 0 circular, 1 linear, 2 hyperbolic, 3 as circular |
| x_i | input | W | Initial x, signed fixed point |
| y_i | input | W | Initial y, signed fixed point |
| z_i | input | W | Initial z (angle in radians), signed fixed point |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when results are valid |
| x_o | output | W | Final x |
| y_o | output | W | Final y |
| z_o | output | W | Final z |

## Verification
When the step counter or the repeat flag is wrong, done_o reaches the ports at the wrong cycle, and the cycle-count checks catch that on the first computation. A wrong entry in the constant table or a reversed steering sign leaves the timing intact but shifts the final words by far more than the tolerance. That error is visible at the done pulse of the first computation that uses the affected system. A load path that samples inputs while busy shows up in the restart test as a result from the second input set or a moved done pulse. A hold path that leaks shows up as output words that change during idle cycles.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic [1:0] {
        SYS_CIRC = 2'd0,
        SYS_LIN  = 2'd1,
        SYS_HYP  = 2'd2,
        SYS_ALT  = 2'd3
    } sys_e;

    typedef enum logic {
        MD_ROT = 1'b0,
        MD_VEC = 1'b1
    } mode_e;

    typedef struct packed {
        logic run;
        logic hyp;
        logic rep;
    } seq_flags_t;

    // Elementary step constant scaled by 2^frac, computed at elaboration.
    function automatic int step_const(sys_e s, int i, int frac);
        real t;
        real v;
        t = 2.0 ** (-i);
        case (s)
            SYS_LIN: v = t;
            SYS_HYP: v = (i == 0) ? 0.0 : 0.5 * $ln((1.0 + t) / (1.0 - t));
            default: v = $atan(t);
        endcase
        return $rtoi(v * (2.0 ** frac) + 0.5);
    endfunction

endpackage

// File: rtl/cordic_rom.sv
module cordic_rom
    import cordic_pkg::*;
#(
    parameter int W    = 18,
    parameter int FRAC = 14,
    parameter int N    = 16,
    localparam int IW  = $clog2(N)
) (
    input  sys_e                 sys_i,
    input  logic [IW-1:0]        idx_i,
    output logic signed [W-1:0]  w_o
);

    logic signed [W-1:0] tab_circ [N];
    logic signed [W-1:0] tab_lin  [N];
    logic signed [W-1:0] tab_hyp  [N];

    for (genvar g = 0; g < N; g++) begin : g_tab
        localparam int CC = step_const(SYS_CIRC, g, FRAC);
        localparam int CL = step_const(SYS_LIN,  g, FRAC);
        localparam int CH = step_const(SYS_HYP,  g, FRAC);
        assign tab_circ[g] = W'(CC);
        assign tab_lin[g]  = W'(CL);
        assign tab_hyp[g]  = W'(CH);
    end

    always_comb begin
        case (sys_i)
            SYS_LIN: w_o = tab_lin[idx_i];
            SYS_HYP: w_o = tab_hyp[idx_i];
            default: w_o = tab_circ[idx_i];
        endcase
    end

endmodule

// File: rtl/cordic_step.sv
module cordic_step
    import cordic_pkg::*;
#(
    parameter int W   = 18,
    parameter int N   = 16,
    localparam int IW = $clog2(N)
) (
    input  sys_e                 sys_i,
    input  mode_e                mode_i,
    input  logic [IW-1:0]        sh_i,
    input  logic signed [W-1:0]  w_i,
    input  logic signed [W-1:0]  x_i,
    input  logic signed [W-1:0]  y_i,
    input  logic signed [W-1:0]  z_i,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o,
    output logic signed [W-1:0]  z_o
);

    logic                neg;   // direction d = -1
    logic signed [W-1:0] xs;
    logic signed [W-1:0] ys;

    always_comb begin
        neg = (mode_i == MD_ROT) ? z_i[W-1] : ~y_i[W-1];
        xs  = x_i >>> sh_i;
        ys  = y_i >>> sh_i;
        y_o = neg ? (y_i - xs) : (y_i + xs);
        z_o = neg ? (z_i + w_i) : (z_i - w_i);
        case (sys_i)
            SYS_LIN: x_o = x_i;
            SYS_HYP: x_o = neg ? (x_i - ys) : (x_i + ys);
            default: x_o = neg ? (x_i + ys) : (x_i - ys);
        endcase
    end

endmodule

// File: rtl/cordic_seq.sv
module cordic_seq
    import cordic_pkg::*;
#(
    parameter int N   = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept_i,
    input  logic          hyp_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [IW-1:0] sh_o
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    seq_flags_t    fl;
    logic [IW-1:0] sh;
    logic          need_rep;
    logic          last;

    always_comb begin
        need_rep = fl.hyp && !fl.rep &&
                   ((int'(sh) == 4) || (int'(sh) == 13));
        last     = (sh == LAST) && !need_rep;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl     <= '0;
            sh     <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept_i) begin
                fl.run <= 1'b1;
                fl.hyp <= hyp_i;
                fl.rep <= 1'b0;
                sh     <= hyp_i ? IW'(1) : '0;
            end else if (fl.run) begin
                if (last) begin
                    fl.run <= 1'b0;
                    done_o <= 1'b1;
                end else if (need_rep) begin
                    fl.rep <= 1'b1;
                end else begin
                    fl.rep <= 1'b0;
                    sh     <= sh + IW'(1);
                end
            end
        end
    end

    assign busy_o = fl.run;
    assign sh_o   = sh;

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
    import cordic_pkg::*;
#(
    parameter int W    = 18,
    parameter int FRAC = 14,
    parameter int N    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [1:0]          sys_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  logic signed [W-1:0] z_i,
    output logic                busy_o,
    output logic                done_o,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o,
    output logic signed [W-1:0] z_o
);

    localparam int IW = $clog2(N);

    logic                accept;
    logic [IW-1:0]       sh;
    logic signed [W-1:0] w;
    logic signed [W-1:0] x_q, y_q, z_q;
    logic signed [W-1:0] x_n, y_n, z_n;
    sys_e                sys_q;
    mode_e               mode_q;

    assign accept = start_i && !busy_o;

    cordic_seq #(.N(N)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .hyp_i    (sys_i == SYS_HYP),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .sh_o     (sh)
    );

    cordic_rom #(.W(W), .FRAC(FRAC), .N(N)) u_rom (
        .sys_i (sys_q),
        .idx_i (sh),
        .w_o   (w)
    );

    cordic_step #(.W(W), .N(N)) u_step (
        .sys_i  (sys_q),
        .mode_i (mode_q),
        .sh_i   (sh),
        .w_i    (w),
        .x_i    (x_q),
        .y_i    (y_q),
        .z_i    (z_q),
        .x_o    (x_n),
        .y_o    (y_n),
        .z_o    (z_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            sys_q  <= SYS_CIRC;
            mode_q <= MD_ROT;
        end else if (accept) begin
            x_q    <= x_i;
            y_q    <= y_i;
            z_q    <= z_i;
            sys_q  <= sys_e'(sys_i);
            mode_q <= mode_e'(mode_i);
        end else if (busy_o) begin
            x_q <= x_n;
            y_q <= y_n;
            z_q <= z_n;
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;
    assign z_o = z_q;

endmodule

// File: rtl/cordic_engine_chk.sv
module cordic_engine_chk #(
    parameter int W = 18,
    parameter int N = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [1:0]          sys_i,
    input logic                busy_o,
    input logic                done_o,
    input logic signed [W-1:0] x_o,
    input logic signed [W-1:0] y_o,
    input logic signed [W-1:0] z_o
);

    localparam int HYP_STEPS = (N - 1) + ((N - 1 >= 4) ? 1 : 0) + ((N - 1 >= 13) ? 1 : 0);

    int   cnt;
    logic hyp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= 0;
            hyp_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            cnt   <= 0;
            hyp_q <= (sys_i == 2'd2);
        end else if (busy_o) begin
            cnt <= cnt + 1;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> (!busy_o && !done_o));

    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r4_fall_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R3: a start while busy must not restart the step count
    a_r3_r4_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cnt == (hyp_q ? HYP_STEPS : N)));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

endmodule

bind cordic_engine cordic_engine_chk #(.W(W), .N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .sys_i   (sys_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .x_o     (x_o),
    .y_o     (y_o),
    .z_o     (z_o)
);

// File: tb/cordic_engine_test.sv
`timescale 1ns/1ps
module cordic_engine_test;

    localparam int  W     = 18;
    localparam int  FRAC  = 14;
    localparam int  N     = 16;
    localparam real SCALE = 2.0 ** FRAC;
    localparam real TOL   = 0.003;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic                mode = 1'b0;
    logic [1:0]          sys = 2'd0;
    logic signed [W-1:0] xi = '0, yi = '0, zi = '0;
    logic                busy, done;
    logic signed [W-1:0] xo, yo, zo;

    int nchk  = 0;
    int nfail = 0;
    real kc, kh;

    always #2 clk = ~clk;

    cordic_engine #(.W(W), .FRAC(FRAC), .N(N)) uut (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode), .sys_i(sys),
        .x_i(xi), .y_i(yi), .z_i(zi),
        .busy_o(busy), .done_o(done), .x_o(xo), .y_o(yo), .z_o(zo)
    );

    function automatic logic signed [W-1:0] to_fix(real r);
        return W'($rtoi(r * SCALE));
    endfunction

    function automatic real to_real(logic signed [W-1:0] v);
        return $itor(v) / SCALE;
    endfunction

    task automatic chk_r(string tag, real act, real exp);
        real e;
        nchk++;
        e = act - exp;
        if (e < 0.0) e = -e;
        if (e > TOL) begin
            nfail++;
            $display("FAIL %s actual=%f expected=%f", tag, act, exp);
        end
    endtask

    task automatic chk_i(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic launch(logic md, logic [1:0] sy, real x, real y, real z);
        mode = md; sys = sy;
        xi = to_fix(x); yi = to_fix(y); zi = to_fix(z);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int c0, output int cyc);
        cyc = c0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!done && cyc < 200);
        if (cyc >= 200) begin
            nfail++;
            $display("FAIL R4 done never seen actual=%0d expected=%0d", cyc, N);
        end
    endtask

    task automatic run_op(logic md, logic [1:0] sy, real x, real y, real z,
                          output real xr, output real yr, output real zr, output int cyc);
        launch(md, sy, x, y, z);
        chk_i("R2 busy after accept", int'(busy), 1);
        wait_done(0, cyc);
        xr = to_real(xo); yr = to_real(yo); zr = to_real(zo);
    endtask

    task automatic t_reset;
        chk_i("R1 busy", int'(busy), 0);
        chk_i("R1 done", int'(done), 0);
        chk_i("R1 x", int'(xo), 0);
        chk_i("R1 y", int'(yo), 0);
        chk_i("R1 z", int'(zo), 0);
    endtask

    task automatic t_circ_rot(real x, real y, real z);
        real a, b, c; int cyc;
        run_op(1'b0, 2'd0, x, y, z, a, b, c, cyc);
        chk_i("R4 circular cycles", cyc, N);
        chk_r("R6 x", a, kc * (x * $cos(z) - y * $sin(z)));
        chk_r("R6 y", b, kc * (y * $cos(z) + x * $sin(z)));
        chk_r("R6 z", c, 0.0);
    endtask

    task automatic t_circ_vec(real x, real y, real z);
        real a, b, c; int cyc;
        run_op(1'b1, 2'd0, x, y, z, a, b, c, cyc);
        chk_r("R7 x", a, kc * $sqrt(x * x + y * y));
        chk_r("R7 y", b, 0.0);
        chk_r("R7 z", c, z + $atan2(y, x));
    endtask

    task automatic t_lin_rot(real x, real y, real z);
        real a, b, c; int cyc;
        run_op(1'b0, 2'd1, x, y, z, a, b, c, cyc);
        chk_i("R4 linear cycles", cyc, N);
        chk_r("R8 x", a, x);
        chk_r("R8 y", b, y + x * z);
        chk_r("R8 z", c, 0.0);
    endtask

    task automatic t_lin_vec(real x, real y, real z);
        real a, b, c; int cyc;
        run_op(1'b1, 2'd1, x, y, z, a, b, c, cyc);
        chk_r("R9 x", a, x);
        chk_r("R9 y", b, 0.0);
        chk_r("R9 z", c, z + y / x);
    endtask

    task automatic t_hyp_rot(real x, real y, real z);
        real a, b, c, ch, sh; int cyc;
        run_op(1'b0, 2'd2, x, y, z, a, b, c, cyc);
        ch = ($exp(z) + $exp(-z)) / 2.0;
        sh = ($exp(z) - $exp(-z)) / 2.0;
        chk_i("R4 R10 hyperbolic cycles", cyc, N + 1);
        chk_r("R10 x", a, kh * (x * ch + y * sh));
        chk_r("R10 y", b, kh * (y * ch + x * sh));
    endtask

    task automatic t_hyp_vec(real x, real y, real z);
        real a, b, c, r; int cyc;
        run_op(1'b1, 2'd2, x, y, z, a, b, c, cyc);
        r = y / x;
        chk_r("R11 x", a, kh * $sqrt(x * x - y * y));
        chk_r("R11 z", c, z + 0.5 * $ln((1.0 + r) / (1.0 - r)));
    endtask

    task automatic t_alt_sys;
        real a, b, c; int cyc;
        run_op(1'b0, 2'd3, 0.7, 0.1, 0.9, a, b, c, cyc);
        chk_i("R12 cycles", cyc, N);
        chk_r("R12 x", a, kc * (0.7 * $cos(0.9) - 0.1 * $sin(0.9)));
        chk_r("R12 y", b, kc * (0.1 * $cos(0.9) + 0.7 * $sin(0.9)));
    endtask

    task automatic t_restart_ignored;
        int cyc;
        launch(1'b0, 2'd0, 0.5, 0.0, 0.6);
        repeat (5) @(negedge clk);
        mode = 1'b1; sys = 2'd2;
        xi = to_fix(0.3); yi = to_fix(-0.2); zi = to_fix(-1.0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(6, cyc);
        chk_i("R3 done timing", cyc, N);
        chk_r("R3 x", to_real(xo), kc * 0.5 * $cos(0.6));
        chk_r("R3 y", to_real(yo), kc * 0.5 * $sin(0.6));
    endtask

    task automatic t_hold;
        logic signed [W-1:0] hx, hy, hz;
        hx = xo; hy = yo; hz = zo;
        xi = to_fix(1.1); yi = to_fix(-0.9); zi = to_fix(0.4);
        mode = 1'b1; sys = 2'd1;
        repeat (6) @(negedge clk);
        chk_i("R5 x held", int'(xo), int'(hx));
        chk_i("R5 y held", int'(yo), int'(hy));
        chk_i("R5 z held", int'(zo), int'(hz));
    endtask

    task automatic t_back_to_back;
        real a, b, c; int cyc;
        run_op(1'b0, 2'd1, 0.5, 0.25, 1.5, a, b, c, cyc);
        // now at the negedge where done is high: start again at once
        launch(1'b0, 2'd1, -0.75, 0.1, 0.5);
        chk_i("R13 busy after back-to-back start", int'(busy), 1);
        wait_done(0, cyc);
        chk_i("R13 cycles", cyc, N);
        chk_r("R13 y", to_real(yo), 0.1 - 0.75 * 0.5);
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        kc = 1.0;
        for (int i = 0; i < N; i++) kc = kc * $sqrt(1.0 + 2.0 ** (-2 * i));
        kh = 1.0;
        for (int i = 1; i < N; i++) begin
            kh = kh * $sqrt(1.0 - 2.0 ** (-2 * i));
            if (i == 4 || i == 13) kh = kh * $sqrt(1.0 - 2.0 ** (-2 * i));
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_circ_rot(1.0, 0.0, 0.5);
        t_circ_rot(0.6, -0.3, -1.2);
        t_circ_rot(0.4, 0.4, 1.5);
        t_circ_vec(0.8, 0.6, 0.0);
        t_circ_vec(0.5, -0.7, 0.1);
        t_lin_rot(0.75, 0.125, -1.25);
        t_lin_rot(-0.5, 0.3, 0.9);
        t_lin_vec(1.0, 0.6, 0.0);
        t_lin_vec(0.8, -1.2, 0.2);
        t_hyp_rot(1.0, 0.0, 0.5);
        t_hyp_rot(0.8, 0.2, -0.9);
        t_hyp_vec(1.0, 0.5, 0.0);
        t_hyp_vec(1.2, -0.6, 0.1);
        t_alt_sys();
        t_hold();
        t_restart_ignored();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule